// File: doc/BRIEF.md
# Postfix Stack Evaluator

This block evaluates reverse Polish (postfix) token streams in hardware. Tokens arrive one per cycle over a valid/ready handshake and are consumed strictly in the order they arrive. A data token goes onto an internal operand stack. An operator token takes the top two entries, combines them and leaves the single result in their place, all in one cycle.

A pop token removes the top entry and presents it on a registered output, so that surrounding logic can store it to memory. Together with data tokens, this lets the block serve as the operand store of a zero-address machine.

The current top of stack and the stack depth are always visible. Two sticky error flags report an attempt to push onto a full stack and an attempt to take more entries than the stack holds. After either error the block refuses all further tokens until reset.

Top module: `rpn_stack_eval`

## Requirements
- R1: After a synchronous active-low reset the stack is empty (`depth` 0, `tos_data` 0), both error flags are low, `out_valid` is low and `tok_ready` is high.
- R2: An accepted token with `tok_kind` 00 (data) and room on the stack places `tok_data` on top. After that clock edge, `depth` is one larger and `tos_data` equals the pushed value.
- R3: An accepted token with `tok_kind` 01 (operator) and at least two entries on the stack pops the right operand (the top) and then the left operand (the entry below it). It pushes `left op right`, so `depth` drops by one. The `tok_op` encodings are: 00 add, 01 subtract (left minus right), 10 multiply, 11 bitwise XOR.
- R4: Every result is truncated to the low DATA_W bits. For example, with DATA_W = 8, 20*20 gives 144 and 7-9 gives 254.
- R5: Tokens are processed strictly in arrival order. The stream 3 4 * 5 6 * + leaves 42 alone on the stack.
- R6: An accepted token with `tok_kind` 10 (pop) on a non-empty stack lowers `depth` by one. In the cycle after the edge, it raises `out_valid` for exactly that cycle, with `out_data` equal to the value that was on top.
- R7: A data token accepted while `depth` equals DEPTH sets `overflow` after the edge and leaves `depth` and the stack contents unchanged.
- R8: An operator token accepted with fewer than two entries, or a pop token accepted on an empty stack, sets `underflow` after the edge. It leaves the stack unchanged and produces no `out_valid`.
- R9: While either error flag is set, `tok_ready` is low, presented tokens have no effect, and the flag stays set until reset.
- R10: An accepted token with `tok_kind` 11 (reserved) changes neither the stack nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_valid | input | 1 | A token is presented |
| tok_ready | output | 1 | Block accepts a token this cycle (low after an error) |
| tok_kind | input | 2 | 00 data, 01 operator, 10 pop, 11 reserved |
| tok_op | input | 2 | Operator code, used with operator tokens |
| tok_data | input | DATA_W | Value of a data token |
| tos_data | output | DATA_W | Current top of stack, 0 when empty |
| depth | output | clog2(DEPTH+1) | Number of entries on the stack |
| out_valid | output | 1 | One-cycle strobe for a popped value |
| out_data | output | DATA_W | Most recently popped value |
| overflow | output | 1 | Sticky flag: push onto a full stack |
| underflow | output | 1 | Sticky flag: too few entries for an operator or pop |

## Verification
The bench builds the block with DATA_W = 8 and DEPTH = 4. The narrow data width makes truncation of sums, differences and products easy to provoke with small operands, such as a negative difference wrapping to 254 and 400 folding to 144. The shallow stack can be filled in four tokens, so the full-stack push, the stalled handshake after an error, and the recovery through reset are all reached within a few dozen cycles.

// File: rtl/rpn_pkg.sv
// Shared encodings for the postfix stack evaluator.
// Assumes two-bit token kind and operator fields at the block boundary.
package rpn_pkg;
    typedef enum logic [1:0] {
        K_PUSH = 2'b00,
        K_OPER = 2'b01,
        K_POP  = 2'b10,
        K_NOP  = 2'b11
    } tok_kind_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;
endpackage

// File: rtl/rpn_alu.sv
// Combinational operator unit: res = lhs <op> rhs, truncated to DATA_W.
// Assumes lhs is the deeper stack entry and rhs is the top entry.
module rpn_alu
    import rpn_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);
    localparam int PW = 2 * DATA_W;

    logic [PW-1:0] prod;

    // Select the operation and keep only the low DATA_W bits
    always_comb begin
        prod = PW'(lhs) * PW'(rhs);
        case (alu_op_e'(op))
            OP_ADD:  res = lhs + rhs;
            OP_SUB:  res = lhs - rhs;
            OP_MUL:  res = prod[DATA_W-1:0];
            default: res = lhs ^ rhs;
        endcase
    end
endmodule

// File: rtl/rpn_stack_store.sv
// Register-array operand stack with a fill counter.
// Exposes the top and second entries combinationally (0 when absent).
// Assumes the controller never writes past the counter or beyond DEPTH.
module rpn_stack_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       cnt_we,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic [DATA_W-1:0]          top,
    output logic [DATA_W-1:0]          second
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Write one entry when it is the addressed slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (wr_en && wr_idx == AW'(g))
                ent[g] <= wr_data;
        end
    end

    // Track the number of live entries
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_we)
            cnt <= cnt_nxt;
    end

    // Read the two uppermost entries, zero when not present
    always_comb begin
        top    = '0;
        second = '0;
        if (cnt != '0)
            top = ent[AW'(cnt - CW'(1))];
        if (cnt >= CW'(2))
            second = ent[AW'(cnt - CW'(2))];
    end

    AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R7
endmodule

// File: rtl/rpn_ctrl.sv
// Token controller: decodes each accepted token into a stack update,
// drives the pop output register and the sticky error flags.
// Assumes DEPTH >= 2 and one token per cycle at most.
module rpn_ctrl
    import rpn_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tok_valid,
    output logic                       tok_ready,
    input  logic [1:0]                 tok_kind,
    input  logic [DATA_W-1:0]          tok_data,
    input  logic [$clog2(DEPTH+1)-1:0] cnt,
    input  logic [DATA_W-1:0]          top,
    input  logic [DATA_W-1:0]          alu_res,
    output logic                       wr_en,
    output logic [$clog2(DEPTH)-1:0]   wr_idx,
    output logic [DATA_W-1:0]          wr_data,
    output logic                       cnt_we,
    output logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_data,
    output logic                       ovf,
    output logic                       udf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    tok_kind_e kind;
    logic      accept;
    logic      set_ovf;
    logic      set_udf;
    logic      pop_fire;

    assign kind      = tok_kind_e'(tok_kind);
    assign tok_ready = !(ovf || udf);
    assign accept    = tok_valid && tok_ready;

    // Decode the accepted token into a stack update or an error
    always_comb begin
        wr_en    = 1'b0;
        wr_idx   = '0;
        wr_data  = '0;
        cnt_we   = 1'b0;
        cnt_nxt  = cnt;
        set_ovf  = 1'b0;
        set_udf  = 1'b0;
        pop_fire = 1'b0;
        if (accept) begin
            case (kind)
                K_PUSH: begin
                    if (cnt == CW'(DEPTH)) begin
                        set_ovf = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_idx  = AW'(cnt);
                        wr_data = tok_data;
                        cnt_we  = 1'b1;
                        cnt_nxt = cnt + CW'(1);
                    end
                end
                K_OPER: begin
                    if (cnt < CW'(2)) begin
                        set_udf = 1'b1;
                    end else begin
                        wr_en   = 1'b1;
                        wr_idx  = AW'(cnt - CW'(2));
                        wr_data = alu_res;
                        cnt_we  = 1'b1;
                        cnt_nxt = cnt - CW'(1);
                    end
                end
                K_POP: begin
                    if (cnt == '0) begin
                        set_udf = 1'b1;
                    end else begin
                        cnt_we   = 1'b1;
                        cnt_nxt  = cnt - CW'(1);
                        pop_fire = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Latch error flags until reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            ovf <= ovf || set_ovf;
            udf <= udf || set_udf;
        end
    end

    // Present a popped value for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pop_fire;
            if (pop_fire)
                out_data <= top;
        end
    end

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_PUSH && cnt < CW'(DEPTH)) |=>
            (cnt == $past(cnt) + CW'(1)) && (top == $past(tok_data))); // R2
    AST_OPER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_OPER && cnt >= CW'(2)) |=>
            (cnt == $past(cnt) - CW'(1)) && (top == $past(alu_res))); // R3
    AST_POP_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_POP && cnt != '0) |=>
            out_valid && (out_data == $past(top)) && (cnt == $past(cnt) - CW'(1))); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_PUSH && cnt == CW'(DEPTH)) |=> ovf && $stable(cnt)); // R7
    AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ((kind == K_OPER && cnt < CW'(2)) || (kind == K_POP && cnt == '0))) |=>
            udf && $stable(cnt) && !out_valid); // R8
    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || udf) |=> (ovf || udf) && $stable(cnt) && !tok_ready); // R9
    AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_NOP) |=> $stable(cnt) && !out_valid); // R10
endmodule

// File: rtl/rpn_stack_eval.sv
// Postfix stack evaluator top: joins the controller, the operand stack
// and the operator unit. The right operand is the top entry, the left
// operand the one below it. Assumes DEPTH >= 2.
module rpn_stack_eval #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tok_valid,
    output logic                       tok_ready,
    input  logic [1:0]                 tok_kind,
    input  logic [1:0]                 tok_op,
    input  logic [DATA_W-1:0]          tok_data,
    output logic [DATA_W-1:0]          tos_data,
    output logic [$clog2(DEPTH+1)-1:0] depth,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_data,
    output logic                       overflow,
    output logic                       underflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic              wr_en;
    logic [AW-1:0]     wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic              cnt_we;
    logic [CW-1:0]     cnt_nxt;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] top;
    logic [DATA_W-1:0] second;
    logic [DATA_W-1:0] alu_res;

    assign tos_data = top;
    assign depth    = cnt;

    rpn_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_ready (tok_ready),
        .tok_kind  (tok_kind),
        .tok_data  (tok_data),
        .cnt       (cnt),
        .top       (top),
        .alu_res   (alu_res),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .cnt_we    (cnt_we),
        .cnt_nxt   (cnt_nxt),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ovf       (overflow),
        .udf       (underflow)
    );

    rpn_stack_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cnt_we  (cnt_we),
        .cnt_nxt (cnt_nxt),
        .cnt     (cnt),
        .top     (top),
        .second  (second)
    );

    rpn_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (tok_op),
        .lhs (second),
        .rhs (top),
        .res (alu_res)
    );
endmodule

// File: tb/rpn_stack_eval_test.sv
// Directed bench for the postfix stack evaluator, DATA_W=8, DEPTH=4.
module rpn_stack_eval_test;
    localparam int DW = 8;
    localparam int DP = 4;
    localparam int CW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_valid = 1'b0;
    logic          tok_ready;
    logic [1:0]    tok_kind = 2'b00;
    logic [1:0]    tok_op = 2'b00;
    logic [DW-1:0] tok_data = '0;
    logic [DW-1:0] tos_data;
    logic [CW-1:0] depth;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          overflow;
    logic          underflow;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    rpn_stack_eval #(.DEPTH(DP), .DATA_W(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .tok_ready (tok_ready),
        .tok_kind  (tok_kind),
        .tok_op    (tok_op),
        .tok_data  (tok_data),
        .tos_data  (tos_data),
        .depth     (depth),
        .out_valid (out_valid),
        .out_data  (out_data),
        .overflow  (overflow),
        .underflow (underflow)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; leaves time at the next falling edge.
    task automatic send(input logic [1:0] k, input logic [1:0] op, input int d);
        tok_kind  = k;
        tok_op    = op;
        tok_data  = DW'(d);
        tok_valid = 1'b1;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic push(input int d);
        send(2'b00, 2'b00, d);
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        tok_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 depth", int'(depth), 0);
        check("R1 tos", int'(tos_data), 0);
        check("R1 ready", int'(tok_ready), 1);
        check("R1 flags", int'({overflow, underflow}), 0);
        check("R1 out_valid", int'(out_valid), 0);
    endtask

    task automatic t_push_ops();
        push(7);
        check("R2 tos", int'(tos_data), 7);
        check("R2 depth", int'(depth), 1);
        push(9);
        check("R2 tos second", int'(tos_data), 9);
        check("R2 depth second", int'(depth), 2);
        send(2'b01, 2'b01, 0);
        check("R3 sub order", int'(tos_data), 254);
        check("R3 depth", int'(depth), 1);
        push(20);
        push(20);
        send(2'b01, 2'b10, 0);
        check("R4 mul truncation", int'(tos_data), 144);
        send(2'b10, 2'b00, 0);
        check("R6 out_valid", int'(out_valid), 1);
        check("R6 out_data", int'(out_data), 144);
        check("R6 tos after pop", int'(tos_data), 254);
        check("R6 depth", int'(depth), 1);
        @(negedge clk);
        check("R6 strobe one cycle", int'(out_valid), 0);
        send(2'b10, 2'b00, 0);
        check("R6 second pop", int'(out_data), 254);
        check("R6 empty", int'(depth), 0);
    endtask

    task automatic t_rpn();
        push(3);
        push(4);
        send(2'b01, 2'b10, 0);
        push(5);
        push(6);
        send(2'b01, 2'b10, 0);
        send(2'b01, 2'b00, 0);
        check("R5 result", int'(tos_data), 42);
        check("R5 depth", int'(depth), 1);
        push(5);
        send(2'b01, 2'b11, 0);
        check("R3 xor", int'(tos_data), 47);
        push(250);
        send(2'b01, 2'b00, 0);
        check("R4 add wrap", int'(tos_data), 41);
        send(2'b10, 2'b00, 0);
    endtask

    task automatic t_reserved();
        push(1);
        send(2'b11, 2'b00, 99);
        check("R10 depth", int'(depth), 1);
        check("R10 tos", int'(tos_data), 1);
        check("R10 no strobe", int'(out_valid), 0);
        check("R10 no flags", int'({overflow, underflow, tok_ready}), 1);
        send(2'b10, 2'b00, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 1; i <= DP; i++) push(i);
        check("R7 full", int'(depth), DP);
        push(55);
        check("R7 overflow", int'(overflow), 1);
        check("R7 depth kept", int'(depth), DP);
        check("R7 tos kept", int'(tos_data), DP);
        check("R9 ready low", int'(tok_ready), 0);
        send(2'b10, 2'b00, 0);
        check("R9 pop ignored depth", int'(depth), DP);
        check("R9 pop ignored strobe", int'(out_valid), 0);
        check("R9 flag held", int'(overflow), 1);
        do_reset();
        check("R9 cleared by reset", int'({overflow, tok_ready}), 1);
    endtask

    task automatic t_underflow();
        do_reset();
        push(8);
        send(2'b01, 2'b00, 0);
        check("R8 oper underflow", int'(underflow), 1);
        check("R8 depth kept", int'(depth), 1);
        check("R8 tos kept", int'(tos_data), 8);
        check("R8 no overflow", int'(overflow), 0);
        do_reset();
        send(2'b10, 2'b00, 0);
        check("R8 pop empty", int'(underflow), 1);
        check("R8 pop no strobe", int'(out_valid), 0);
        push(3);
        check("R9 push ignored", int'(depth), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_push_ops();
        t_rpn();
        t_reserved();
        t_overflow();
        t_underflow();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule